// File: doc/BRIEF.md
# Keyboard controller port trap sequencer

This block sits beside the I/O decode path of a system chip. It watches each I/O cycle aimed at the legacy keyboard controller, either at the data port (address 60h) or at the command/status port (address 64h). For every such cycle it decides two things: whether the cycle is forwarded to the keyboard controller or held back (trapped), and whether a system-management interrupt (SMI) is raised. An 8-bit trap configuration word, supplied by the surrounding register logic, holds one trap enable per port and direction, plus one enable for an SMI at the end of a gate-A20 sequence.

The gate-A20 sequence is a command write of D1h to 64h, then any data write to 60h, then a command write of FFh to 64h. A three-state tracker (idle, armed, latched) follows this sequence. While a sequence is in progress, the tracker overrides the per-port trap enables so that the steps of the sequence always reach the controller. A sequence-active status output is high exactly while the tracker is out of idle. Both decisions are registered together with the next tracker state. Each result appears as a one-cycle pulse in the cycle after the valid strobe.

Top module: `kbt_gate_trap`

## Requirements
- R1: In idle, a command write (port 64h) of D1h moves to armed. It is forwarded, raises no SMI, and sets the sequence-active output to 1.
- R2: In idle, every other cycle stays in idle, and a configuration bit decides its handling: bit 0 for a data read, bit 1 for a data write, bit 2 for a command read, bit 3 for a command write. A set bit blocks the cycle (forward 0) and raises an SMI. A clear bit forwards it with no SMI.
- R3: In armed, a data write (port 60h) of any value moves to latched. It is forwarded with no SMI whatever bit 1 holds, and sequence-active stays 1.
- R4: In armed, a repeated command write of D1h stays in armed. It is forwarded with no SMI whatever bit 3 holds.
- R5: In armed, a command write other than D1h returns to idle. Its handling follows bit 3, an SMI is also raised when bit 7 is set, and sequence-active clears.
- R6: In armed, a data read returns to idle. Its handling follows bit 0, an SMI is also raised when bit 7 is set, and sequence-active clears.
- R7: In armed or latched, a command read keeps the state, follows bit 2 for forwarding and SMI, and leaves sequence-active at 1.
- R8: In latched, a command write of FFh returns to idle. It is forwarded whatever bit 3 holds, sequence-active clears, and an SMI is raised exactly when bit 7 is set.
- R9: In latched, a command write other than FFh returns to idle. Its handling follows bit 3, bit 7 set also raises an SMI, and sequence-active clears.
- R10: In latched, a data read or data write is forwarded with no SMI and no change of state.
- R11: A valid cycle to any address other than the two ports produces no forward and no SMI pulse, and leaves the tracker state unchanged.
- R12: Forward and SMI are one-cycle pulses that appear in the cycle after the valid strobe. Both are 0 in any cycle that does not follow a valid port cycle.
- R13: A synchronous reset returns the tracker to idle and clears the forward, SMI and sequence-active outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | One-cycle strobe marking an I/O cycle |
| cyc_addr | input | ADDR_W (16) | I/O address of the cycle |
| cyc_write | input | 1 | 1 for a write, 0 for a read |
| cyc_wdata | input | 8 | Write data byte |
| trap_cfg | input | 8 | Trap enables: bits 0..3 per port and direction, bit 7 SMI at sequence end |
| fwd_o | output | 1 | Pulse: pass the cycle to the keyboard controller |
| smi_o | output | 1 | Pulse: raise a system-management interrupt |
| seq_active_o | output | 1 | High while a gate-A20 sequence is in progress |

## Verification
Every result of this block (the forward pulse, the SMI pulse and the updated sequence-active level) is due exactly one clock after the edge that samples the valid strobe. The bench therefore drives a cycle at a falling edge and drops the strobe at the next falling edge. It reads all three outputs at that point, half a period after the rising edge that registered them. A second sample one full cycle later, in the idle-pulse test, shows that the pulses have fallen while the sequence-active level holds.

// File: rtl/kbt_pkg.sv
package kbt_pkg;

    localparam int KBT_ADDR_W     = 16;
    localparam int KBT_CFG_W      = 8;
    localparam int KBT_DATA_W     = 8;

    // trap configuration bit positions
    localparam int CFG_DATA_RD    = 0;
    localparam int CFG_DATA_WR    = 1;
    localparam int CFG_CMD_RD     = 2;
    localparam int CFG_CMD_WR     = 3;
    localparam int CFG_SEQ_END    = 7;

    typedef enum logic [1:0] {
        GS_IDLE    = 2'd0,
        GS_ARMED   = 2'd1,
        GS_LATCHED = 2'd2
    } gate_state_e;

    typedef enum logic [1:0] {
        CK_DATA_RD = 2'd0,
        CK_DATA_WR = 2'd1,
        CK_CMD_RD  = 2'd2,
        CK_CMD_WR  = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        logic        hit;
        cyc_kind_e   kind;
    } cyc_class_t;

    typedef struct packed {
        gate_state_e next;
        logic        fwd;
        logic        smi;
    } decision_t;

    // configuration bit that governs one kind of cycle
    function automatic int unsigned cfg_index(input cyc_kind_e k);
        case (k)
            CK_DATA_RD: cfg_index = CFG_DATA_RD;
            CK_DATA_WR: cfg_index = CFG_DATA_WR;
            CK_CMD_RD:  cfg_index = CFG_CMD_RD;
            default:    cfg_index = CFG_CMD_WR;
        endcase
    endfunction

    // decision that follows the per-port trap bit, optionally with the sequence-end SMI
    function automatic decision_t by_trap(input logic trap, input logic end_smi,
                                          input gate_state_e nxt);
        decision_t d;
        d.next = nxt;
        d.fwd  = ~trap;
        d.smi  = trap | end_smi;
        return d;
    endfunction

endpackage

// File: rtl/kbt_classify.sv
module kbt_classify
    import kbt_pkg::*;
#(
    parameter int                ADDR_W    = KBT_ADDR_W,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output cyc_class_t        cls
);
    logic is_data;
    logic is_cmd;

    always_comb begin
        is_data  = (addr == DATA_PORT);
        is_cmd   = (addr == CMD_PORT);
        cls.hit  = valid & (is_data | is_cmd);
        cls.kind = cyc_kind_e'({is_cmd, write});
    end

    always_comb begin
        assert (!(is_data && is_cmd))
            else $error("p_ports_distinct_r11: data and command port decode overlap");
    end
endmodule

// File: rtl/kbt_policy.sv
module kbt_policy
    import kbt_pkg::*;
#(
    parameter int                  CFG_W    = KBT_CFG_W,
    parameter int                  DATA_W   = KBT_DATA_W,
    parameter logic [DATA_W-1:0]   GATE_CMD = 'hD1,
    parameter logic [DATA_W-1:0]   END_CMD  = 'hFF
) (
    input  gate_state_e        state,
    input  cyc_kind_e          kind,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CFG_W-1:0]   cfg,
    output decision_t          dec
);
    logic trap;
    logic end_smi;
    logic is_gate;
    logic is_end;

    always_comb begin
        trap    = cfg[cfg_index(kind)];
        end_smi = cfg[CFG_SEQ_END];
        is_gate = (wdata == GATE_CMD);
        is_end  = (wdata == END_CMD);
        dec     = by_trap(trap, 1'b0, state);
        unique case (state)
            GS_IDLE: begin
                if (kind == CK_CMD_WR && is_gate)
                    dec = '{next: GS_ARMED, fwd: 1'b1, smi: 1'b0};
            end
            GS_ARMED: begin
                unique case (kind)
                    CK_DATA_WR: dec = '{next: GS_LATCHED, fwd: 1'b1, smi: 1'b0};
                    CK_CMD_WR: begin
                        if (is_gate) dec = '{next: GS_ARMED, fwd: 1'b1, smi: 1'b0};
                        else         dec = by_trap(trap, end_smi, GS_IDLE);
                    end
                    CK_DATA_RD: dec = by_trap(trap, end_smi, GS_IDLE);
                    CK_CMD_RD:  dec = by_trap(trap, 1'b0, GS_ARMED);
                endcase
            end
            GS_LATCHED: begin
                unique case (kind)
                    CK_CMD_WR: begin
                        if (is_end) dec = '{next: GS_IDLE, fwd: 1'b1, smi: end_smi};
                        else        dec = by_trap(trap, end_smi, GS_IDLE);
                    end
                    CK_CMD_RD: dec = by_trap(trap, 1'b0, GS_LATCHED);
                    default:   dec = '{next: GS_LATCHED, fwd: 1'b1, smi: 1'b0};
                endcase
            end
            default: dec = '{next: GS_IDLE, fwd: 1'b1, smi: 1'b0};
        endcase
    end
endmodule

// File: rtl/kbt_state.sv
module kbt_state
    import kbt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  decision_t   dec,
    output gate_state_e state,
    output logic        fwd_q,
    output logic        smi_q,
    output logic        active_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= GS_IDLE;
            fwd_q    <= 1'b0;
            smi_q    <= 1'b0;
            active_q <= 1'b0;
        end else begin
            fwd_q <= take & dec.fwd;
            smi_q <= take & dec.smi;
            if (take) begin
                state    <= dec.next;
                active_q <= (dec.next != GS_IDLE);
            end
        end
    end

    // R13: reset leaves the tracker idle with all outputs low
    p_reset_idle_r13: assert property (@(posedge clk)
        rst |=> (state == GS_IDLE && !fwd_q && !smi_q && !active_q));

    // R11: the state register only moves on a port cycle
    p_hold_without_take_r11: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(state));

    // R12: a pulse is only seen after an accepted cycle
    p_pulse_after_take_r12: assert property (@(posedge clk) disable iff (rst)
        (fwd_q || smi_q) |-> $past(take));

    p_state_legal: assert property (@(posedge clk) disable iff (rst)
        state != 2'd3);
endmodule

// File: rtl/kbt_gate_trap.sv
module kbt_gate_trap
    import kbt_pkg::*;
#(
    parameter int                ADDR_W    = KBT_ADDR_W,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64,
    parameter logic [7:0]        GATE_CMD  = 8'hD1,
    parameter logic [7:0]        END_CMD   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_write,
    input  logic [7:0]        cyc_wdata,
    input  logic [7:0]        trap_cfg,
    output logic              fwd_o,
    output logic              smi_o,
    output logic              seq_active_o
);
    cyc_class_t  cls;
    decision_t   dec;
    gate_state_e state;

    kbt_classify #(
        .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
    ) u_classify (
        .valid(cyc_valid), .addr(cyc_addr), .write(cyc_write), .cls(cls)
    );

    kbt_policy #(
        .CFG_W(8), .DATA_W(8), .GATE_CMD(GATE_CMD), .END_CMD(END_CMD)
    ) u_policy (
        .state(state), .kind(cls.kind), .wdata(cyc_wdata), .cfg(trap_cfg), .dec(dec)
    );

    kbt_state u_state (
        .clk(clk), .rst(rst), .take(cls.hit), .dec(dec), .state(state),
        .fwd_q(fwd_o), .smi_q(smi_o), .active_q(seq_active_o)
    );

    // R1: sequence-active only rises after a gate command write
    p_arm_on_gate_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_active_o) |-> $past(cyc_valid && cyc_addr == CMD_PORT && cyc_write
                                      && cyc_wdata == GATE_CMD));

    // R3: a data write while armed always passes with no SMI
    p_armed_data_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (state == GS_ARMED && cyc_valid && cyc_addr == DATA_PORT && cyc_write)
        |=> (fwd_o && !smi_o && seq_active_o));

    // R8: the proper end is forwarded and closes the sequence
    p_proper_end_r8: assert property (@(posedge clk) disable iff (rst)
        (state == GS_LATCHED && cyc_valid && cyc_addr == CMD_PORT && cyc_write
         && cyc_wdata == END_CMD) |=> (fwd_o && !seq_active_o));

    // R11: foreign addresses produce no pulse
    p_foreign_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_addr != DATA_PORT && cyc_addr != CMD_PORT)
        |=> (!fwd_o && !smi_o));
endmodule

// File: tb/tb_kbt_gate_trap.sv
module tb_kbt_gate_trap;
    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_valid;
    logic [15:0] cyc_addr;
    logic        cyc_write;
    logic [7:0]  cyc_wdata;
    logic [7:0]  trap_cfg;
    logic        fwd_o, smi_o, seq_active_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    kbt_gate_trap dut (
        .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
        .cyc_write(cyc_write), .cyc_wdata(cyc_wdata), .trap_cfg(trap_cfg),
        .fwd_o(fwd_o), .smi_o(smi_o), .seq_active_o(seq_active_o)
    );

    typedef struct packed {
        logic       cmd;    // 1: port 64h, 0: port 60h
        logic       wr;
        logic [7:0] data;
        logic [7:0] cfg;
        logic       fwd;
        logic       smi;
        logic       act;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 8'h20, 8'h08, 1'b0, 1'b1, 1'b0, 8'd2},   // R2 cmd write trapped
        '{1'b1, 1'b1, 8'h20, 8'h00, 1'b1, 1'b0, 1'b0, 8'd2},   // R2 cmd write passed
        '{1'b1, 1'b0, 8'h00, 8'h04, 1'b0, 1'b1, 1'b0, 8'd2},   // R2 cmd read trapped
        '{1'b0, 1'b1, 8'h55, 8'h02, 1'b0, 1'b1, 1'b0, 8'd2},   // R2 data write trapped
        '{1'b0, 1'b0, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0, 8'd2},   // R2 data read trapped
        '{1'b0, 1'b0, 8'h00, 8'h0E, 1'b1, 1'b0, 1'b0, 8'd2},   // R2 other bits ignored
        '{1'b1, 1'b1, 8'hD1, 8'hFF, 1'b1, 1'b0, 1'b1, 8'd1},   // R1 arm
        '{1'b1, 1'b1, 8'hD1, 8'h08, 1'b1, 1'b0, 1'b1, 8'd4},   // R4 double trigger
        '{1'b1, 1'b0, 8'h00, 8'h04, 1'b0, 1'b1, 1'b1, 8'd7},   // R7 armed read trapped
        '{1'b0, 1'b1, 8'hDF, 8'h02, 1'b1, 1'b0, 1'b1, 8'd3},   // R3 to latched
        '{1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 8'd7},   // R7 latched read passed
        '{1'b0, 1'b1, 8'h12, 8'h02, 1'b1, 1'b0, 1'b1, 8'd10},  // R10 data write
        '{1'b0, 1'b0, 8'h00, 8'h01, 1'b1, 1'b0, 1'b1, 8'd10},  // R10 data read
        '{1'b1, 1'b1, 8'hFF, 8'h88, 1'b1, 1'b1, 1'b0, 8'd8},   // R8 end with bit 7
        '{1'b1, 1'b1, 8'hD1, 8'h00, 1'b1, 1'b0, 1'b1, 8'd1},
        '{1'b0, 1'b1, 8'hDD, 8'h00, 1'b1, 1'b0, 1'b1, 8'd3},
        '{1'b1, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 8'd8},   // R8 end, no SMI
        '{1'b1, 1'b1, 8'hD1, 8'h00, 1'b1, 1'b0, 1'b1, 8'd1},
        '{1'b1, 1'b1, 8'hAA, 8'h08, 1'b0, 1'b1, 1'b0, 8'd5},   // R5 abort trapped
        '{1'b1, 1'b1, 8'hD1, 8'h00, 1'b1, 1'b0, 1'b1, 8'd1},
        '{1'b1, 1'b1, 8'hAA, 8'h80, 1'b1, 1'b1, 1'b0, 8'd5},   // R5 abort bit 7
        '{1'b1, 1'b1, 8'hD1, 8'h00, 1'b1, 1'b0, 1'b1, 8'd1},
        '{1'b0, 1'b0, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0, 8'd6},   // R6 invalid trapped
        '{1'b1, 1'b1, 8'hD1, 8'h00, 1'b1, 1'b0, 1'b1, 8'd1},
        '{1'b0, 1'b0, 8'h00, 8'h80, 1'b1, 1'b1, 1'b0, 8'd6},   // R6 invalid bit 7
        '{1'b1, 1'b1, 8'hD1, 8'h00, 1'b1, 1'b0, 1'b1, 8'd1},
        '{1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 8'd3},
        '{1'b1, 1'b1, 8'hD1, 8'h08, 1'b0, 1'b1, 1'b0, 8'd9},   // R9 improper end trapped
        '{1'b1, 1'b1, 8'hD1, 8'h00, 1'b1, 1'b0, 1'b1, 8'd1},
        '{1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 8'd3},
        '{1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'd9}    // R9 improper end passed
    };

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: {fwd,smi,act} got=%b exp=%b", req, got, exp);
        end
    endtask

    // drive one cycle for one clock and sample one clock later
    task automatic run_cyc(input logic [15:0] a, input logic w, input logic [7:0] d,
                           input logic [7:0] c);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_addr = a; cyc_write = w; cyc_wdata = d; trap_cfg = c;
        @(negedge clk);
        cyc_valid = 1'b0;
    endtask

    function automatic logic [15:0] port(input logic cmd);
        return cmd ? 16'h0064 : 16'h0060;
    endfunction

    initial begin
        rst = 1'b1; cyc_valid = 1'b0; cyc_addr = '0; cyc_write = 1'b0;
        cyc_wdata = '0; trap_cfg = '0;
        repeat (3) @(negedge clk);
        check("R13 reset", {fwd_o, smi_o, seq_active_o}, 3'b000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_cyc(port(VECS[i].cmd), VECS[i].wr, VECS[i].data, VECS[i].cfg);
            check($sformatf("R%0d vec%0d", VECS[i].req, i),
                  {fwd_o, smi_o, seq_active_o}, {VECS[i].fwd, VECS[i].smi, VECS[i].act});
        end

        // R12: pulses fall in the next cycle while sequence-active holds
        run_cyc(16'h0064, 1'b1, 8'hD1, 8'h00);
        check("R12 pulse", {fwd_o, smi_o, seq_active_o}, 3'b101);
        @(negedge clk);
        check("R12 idle cycle", {fwd_o, smi_o, seq_active_o}, 3'b001);

        // R11: foreign address ignored; the tracker stays armed
        run_cyc(16'h0061, 1'b1, 8'h00, 8'h0F);
        check("R11 foreign", {fwd_o, smi_o, seq_active_o}, 3'b001);
        run_cyc(16'h0065, 1'b1, 8'hFF, 8'h8F);
        check("R11 foreign cmd", {fwd_o, smi_o, seq_active_o}, 3'b001);
        // still armed: a non-gate command write with bit 3 is an aborted sequence
        run_cyc(16'h0064, 1'b1, 8'hFF, 8'h08);
        check("R11 state kept (R5)", {fwd_o, smi_o, seq_active_o}, 3'b010);

        // R13: reset mid-sequence returns to idle behaviour
        run_cyc(16'h0064, 1'b1, 8'hD1, 8'h00);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R13 mid reset", {fwd_o, smi_o, seq_active_o}, 3'b000);
        run_cyc(16'h0060, 1'b1, 8'h00, 8'h02);
        check("R13 idle after reset", {fwd_o, smi_o, seq_active_o}, 3'b010);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=timeout exp=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule